// File: doc/BRIEF.md
# UART Interrupt Flag Aggregator

This block keeps the ten status flags of a serial port together with one enable bit per flag, and from them derives three interrupt request lines. The transmit line serves the two transmitter flags, the receive line serves four receiver flags, and the error line serves four receive-error flags. Driver software can either take interrupts or leave every enable off and poll the flag vector. A flag records its event whether or not it is enabled.

Two transmitter flags are levels. One follows the transmitter's "buffer can take another character" state. The other follows its "everything has been sent and the line rests at its inactive level" state. The eight receiver and error flags are sticky. A one-cycle event strobe sets each of them, and only a clear strobe from the register interface removes it. The strobe sources and the bus decoding that produces the clear strobes sit outside this block.

Flag bit positions: 0 transmit buffer empty, 1 transmit finished, 2 receive data ready, 3 line idle, 4 receive-line edge, 5 break detected, 6 overrun, 7 noise, 8 framing error, 9 parity error. Event strobe bit n sets flag bit n+2.

Top module: `uart_irq_agg`

## Requirements
- R1: While reset is asserted, all ten flag bits and all three request outputs are 0.
- R2: An event strobe on `evt_i[n]` sets flag bit n+2 on the next clock edge, and that bit stays 1 with no further strobe.
- R3: A clear strobe on `flag_clr_i[k]` (k from 2 to 9) with no event for that flag in the same cycle clears flag bit k on the next clock edge.
- R4: When the event strobe and the clear strobe of a sticky flag arrive in the same cycle, the flag is 1 after the edge.
- R5: Flag bits 0 and 1 show `tx_buf_empty_i` and `tx_done_i` as sampled on the previous clock edge. Clear strobes on bits 0 and 1 have no effect.
- R6: A flag whose enable bit is 0 still sets and reads back as 1, and it raises no request.
- R7: `irq_tx_o` is 1 exactly when, one edge earlier, flag bit 0 or 1 was 1 with its enable bit set.
- R8: `irq_rx_o` is 1 exactly when, one edge earlier, any of flag bits 2 to 5 was 1 with its enable bit set.
- R9: `irq_err_o` is 1 exactly when, one edge earlier, any of flag bits 6 to 9 was 1 with its enable bit set.
- R10: A request stays high while at least one enabled flag of its group stays set. It drops one edge after the last such flag clears or loses its enable.
- R11: A flag in one group never raises the request of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_buf_empty_i | input | 1 | Transmitter can accept another character (level) |
| tx_done_i | input | 1 | Transmitter has finished and the line is idle (level) |
| evt_i | input | 8 | One-cycle event strobes, bit n sets flag n+2 |
| flag_clr_i | input | 10 | One-cycle clear strobes, bit k clears sticky flag k |
| irq_en_i | input | 10 | Per-flag request enable |
| flags_o | output | 10 | Registered flag vector for polling |
| irq_tx_o | output | 1 | Transmit interrupt request (level) |
| irq_rx_o | output | 1 | Receive interrupt request (level) |
| irq_err_o | output | 1 | Error interrupt request (level) |

## Verification
A wrong flag register shows on `flags_o` one edge after the strobe that should have changed it. A lost set, a clear that fails to act, or a clear that beats a same-cycle event each appear in that first sample. A wrong enable gate or a wrong group wiring appears on the request lines one edge later. The directed scenarios therefore check flags one cycle after each stimulus, check requests in the cycle that follows, and then hold the inputs steady for several cycles so that a flag which leaks away is caught.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt flag aggregator.
// Assumes the flag vector is laid out as transmit group, then receive group,
// then error group, from bit 0 upward.
package uart_irq_pkg;
    localparam int N_TX    = 2;
    localparam int N_RX    = 4;
    localparam int N_ERR   = 4;
    localparam int N_SRC   = N_TX + N_RX + N_ERR;
    localparam int N_EVT   = N_RX + N_ERR;
    localparam int TX_LO   = 0;
    localparam int RX_LO   = TX_LO + N_TX;
    localparam int ERR_LO  = RX_LO + N_RX;
endpackage

// File: rtl/uart_irq_flag_cell.sv
// One status flag register.
// LEVEL=1: the flag copies its source each cycle, and the clear input is ignored.
// LEVEL=0: the flag is sticky. The source sets it, the clear input clears it,
// and a set beats a clear in the same cycle.
// Assumes the set and clear inputs are one-cycle strobes that are synchronous to clk.
module uart_irq_flag_cell #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic flag_o
);
    generate
        if (LEVEL) begin : g_level
            // Follow the source level, one edge late
            always_ff @(posedge clk) begin
                if (!rst_n) flag_o <= 1'b0;
                else        flag_o <= src_i;
            end
            logic unused_clr;
            assign unused_clr = clr_i;
        end else begin : g_sticky
            // Set on strobe, hold, clear on clear strobe; set has priority
            always_ff @(posedge clk) begin
                if (!rst_n)     flag_o <= 1'b0;
                else if (src_i) flag_o <= 1'b1;
                else if (clr_i) flag_o <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_irq_req.sv
// Registered interrupt request for one group of flags.
// The request is the OR of the group's flags, each gated by its enable bit,
// and it is registered once.
// Assumes flags_i comes from registers, so the request trails the flags by one edge.
module uart_irq_req #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] en_i,
    output logic         req_o
);
    logic any_live;

    // Combine the enabled flags of the group
    always_comb any_live = |(flags_i & en_i);

    // Register the request level
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= any_live;
    end
endmodule

// File: rtl/uart_irq_agg.sv
// UART interrupt flag aggregator (top).
// Holds ten status flags (two transmit levels and eight sticky receive and error
// events) and drives three registered request lines, one for each group.
// Assumes the strobes and the transmitter levels are synchronous to clk.
module uart_irq_agg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_buf_empty_i,
    input  logic             tx_done_i,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_SRC-1:0] flag_clr_i,
    input  logic [N_SRC-1:0] irq_en_i,
    output logic [N_SRC-1:0] flags_o,
    output logic             irq_tx_o,
    output logic             irq_rx_o,
    output logic             irq_err_o
);
    logic [N_SRC-1:0] src;

    // Map the transmitter levels and the event strobes onto flag positions
    always_comb begin
        src = '0;
        src[TX_LO]     = tx_buf_empty_i;
        src[TX_LO + 1] = tx_done_i;
        src[N_SRC-1:RX_LO] = evt_i;
    end

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_flag
            uart_irq_flag_cell #(.LEVEL(i < N_TX)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_i  (src[i]),
                .clr_i  (flag_clr_i[i]),
                .flag_o (flags_o[i])
            );
        end
    endgenerate

    uart_irq_req #(.W(N_TX)) u_req_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_o[TX_LO +: N_TX]),
        .en_i    (irq_en_i[TX_LO +: N_TX]),
        .req_o   (irq_tx_o)
    );

    uart_irq_req #(.W(N_RX)) u_req_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_o[RX_LO +: N_RX]),
        .en_i    (irq_en_i[RX_LO +: N_RX]),
        .req_o   (irq_rx_o)
    );

    uart_irq_req #(.W(N_ERR)) u_req_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_o[ERR_LO +: N_ERR]),
        .en_i    (irq_en_i[ERR_LO +: N_ERR]),
        .req_o   (irq_err_o)
    );
endmodule

// File: rtl/uart_irq_agg_chk.sv
// Property checker for uart_irq_agg, attached through bind.
// Observes the ports only.
module uart_irq_agg_chk
    import uart_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tx_buf_empty_i,
    input logic             tx_done_i,
    input logic [N_EVT-1:0] evt_i,
    input logic [N_SRC-1:0] flag_clr_i,
    input logic [N_SRC-1:0] irq_en_i,
    input logic [N_SRC-1:0] flags_o,
    input logic             irq_tx_o,
    input logic             irq_rx_o,
    input logic             irq_err_o
);
    // R2 R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_o[N_SRC-1:RX_LO] & $past(evt_i)) == $past(evt_i)));

    // R3
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_clr_i[N_SRC-1:RX_LO] & ~evt_i))
        |=> ((flags_o[N_SRC-1:RX_LO] & $past(flag_clr_i[N_SRC-1:RX_LO] & ~evt_i)) == '0));

    // R5
    tx_level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (flags_o[TX_LO +: N_TX] == $past({tx_done_i, tx_buf_empty_i})));

    // R7
    irq_tx_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_tx_o == $past(|(flags_o[TX_LO +: N_TX] & irq_en_i[TX_LO +: N_TX]))));

    // R8
    irq_rx_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_rx_o == $past(|(flags_o[RX_LO +: N_RX] & irq_en_i[RX_LO +: N_RX]))));

    // R9
    irq_err_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_err_o == $past(|(flags_o[ERR_LO +: N_ERR] & irq_en_i[ERR_LO +: N_ERR]))));
endmodule

bind uart_irq_agg uart_irq_agg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_buf_empty_i (tx_buf_empty_i),
    .tx_done_i      (tx_done_i),
    .evt_i          (evt_i),
    .flag_clr_i     (flag_clr_i),
    .irq_en_i       (irq_en_i),
    .flags_o        (flags_o),
    .irq_tx_o       (irq_tx_o),
    .irq_rx_o       (irq_rx_o),
    .irq_err_o      (irq_err_o)
);

// File: tb/uart_irq_agg_bench.sv
// Directed bench for uart_irq_agg: one task per scenario, each checking its own results.
module uart_irq_agg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_buf_empty_i = 1'b0;
    logic       tx_done_i = 1'b0;
    logic [7:0] evt_i = '0;
    logic [9:0] flag_clr_i = '0;
    logic [9:0] irq_en_i = '0;
    logic [9:0] flags_o;
    logic       irq_tx_o, irq_rx_o, irq_err_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_agg u_uart_irq_agg (
        .clk(clk), .rst_n(rst_n),
        .tx_buf_empty_i(tx_buf_empty_i), .tx_done_i(tx_done_i),
        .evt_i(evt_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
        .flags_o(flags_o), .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) step();
        // R1
        check(flags_o == 10'h0, "R1 flags", flags_o, 0);
        check({irq_tx_o, irq_rx_o, irq_err_o} == 3'b000, "R1 irqs",
              {irq_tx_o, irq_rx_o, irq_err_o}, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_level();
        irq_en_i = 10'h001;
        tx_buf_empty_i = 1'b1;
        step();
        // R5
        check(flags_o[1:0] == 2'b01, "R5 level follow", flags_o[1:0], 1);
        flag_clr_i = 10'h003;
        step();
        flag_clr_i = '0;
        // R5 clear ignored, R7 request one edge after flag
        check(flags_o[1:0] == 2'b01, "R5 clear ignored", flags_o[1:0], 1);
        check(irq_tx_o == 1'b1, "R7 tx request", irq_tx_o, 1);
        tx_buf_empty_i = 1'b0;
        tx_done_i = 1'b1;
        step();
        check(flags_o[1:0] == 2'b10, "R5 done level", flags_o[1:0], 2);
        step();
        // R7 done flag not enabled -> no request
        check(irq_tx_o == 1'b0, "R7 tx masked", irq_tx_o, 0);
        tx_done_i = 1'b0;
        irq_en_i = '0;
        repeat (2) step();
    endtask

    task automatic t_sticky();
        evt_i = 8'h01;
        step();
        evt_i = '0;
        repeat (4) step();
        // R2
        check(flags_o[2] == 1'b1, "R2 sticky hold", flags_o, 10'h004);
        flag_clr_i = 10'h004;
        step();
        flag_clr_i = '0;
        // R3
        check(flags_o == 10'h000, "R3 clear", flags_o, 0);
    endtask

    task automatic t_setwins();
        evt_i = 8'h40;
        flag_clr_i = 10'h100;
        step();
        evt_i = '0;
        flag_clr_i = '0;
        // R4
        check(flags_o[8] == 1'b1, "R4 set beats clear", flags_o, 10'h100);
        flag_clr_i = 10'h100;
        step();
        flag_clr_i = '0;
        check(flags_o == 10'h000, "R3 clear framing", flags_o, 0);
    endtask

    task automatic t_mask();
        evt_i = 8'h80;
        step();
        evt_i = '0;
        repeat (3) step();
        // R6
        check(flags_o == 10'h200, "R6 masked flag readable", flags_o, 10'h200);
        check(irq_err_o == 1'b0, "R6 masked no request", irq_err_o, 0);
        irq_en_i = 10'h200;
        step();
        // R9
        check(irq_err_o == 1'b1, "R9 err request", irq_err_o, 1);
        irq_en_i = '0;
        step();
        // R10 enable removed
        check(irq_err_o == 1'b0, "R10 drop on disable", irq_err_o, 0);
        flag_clr_i = 10'h200;
        step();
        flag_clr_i = '0;
    endtask

    task automatic t_groups();
        irq_en_i = 10'h3FE;
        evt_i = 8'h0A;
        step();
        evt_i = '0;
        step();
        // R8 R11
        check(irq_rx_o == 1'b1, "R8 rx request", irq_rx_o, 1);
        check({irq_tx_o, irq_err_o} == 2'b00, "R11 group isolation",
              {irq_tx_o, irq_err_o}, 0);
        flag_clr_i = 10'h008;
        step();
        flag_clr_i = '0;
        step();
        // R10 one flag left
        check(irq_rx_o == 1'b1, "R10 stays high", irq_rx_o, 1);
        flag_clr_i = 10'h020;
        step();
        flag_clr_i = '0;
        check(flags_o == 10'h000, "R3 all cleared", flags_o, 0);
        step();
        check(irq_rx_o == 1'b0, "R10 drops", irq_rx_o, 0);
        evt_i = 8'h10;
        step();
        evt_i = '0;
        step();
        // R9 R11
        check({irq_tx_o, irq_rx_o, irq_err_o} == 3'b001, "R11 err only",
              {irq_tx_o, irq_rx_o, irq_err_o}, 1);
    endtask

    initial begin
        t_reset();
        t_level();
        t_sticky();
        t_setwins();
        t_mask();
        t_groups();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule